// File: doc/BRIEF.md
# Message-Counted Scrambler Key Renewal Controller

This block sits at one end of a fast scrambled link and supplies the 64-bit configuration key for the bit-permuting network on that link. A 128-bit seed, delivered once per activation over a separate protected path, starts a pseudo-random generator. The generator emits one byte per enabled cycle. Each group of eight bytes forms one key, which goes into a small first-in first-out buffer.

The key on the output stays fixed for a programmable number of accepted messages, called the renewal period. After the last message of a window, the next key is taken from the buffer. Because keys change only at message-count boundaries, two copies of the block fed the same seed and the same message sequence produce the same key sequence, with no extra handshake between them. The generator is clock-gated whenever the buffer is full. If the buffer is empty when a new key is needed, traffic is stalled until a key is ready.

The renewal period is held below a programmable security limit. Any write that would break this rule is clamped.

Top module: `keyren_top`

## Requirements
- R1: After synchronous reset, `stall` is 1, `prng_en` is 0 and `key_out` is 0. The renewal period is 4 and the limit is 64.
- R2: A cycle with `seed_load` high loads `seed_data` into the generator state. In the same cycle it empties the key buffer, discards any partly built key, and restarts the message window so that the block waits for a new key. The window restarts even when the buffer still held keys.
- R3: On each enabled cycle the 128-bit generator state `s` performs eight single-bit shifts. Each shift computes `f = s[127]^s[125]^s[100]^s[98]` and sets `s = {s[126:0], f}`. The eight `f` bits form the output byte, with the first one in bit 0. Eight consecutive bytes form one key, with the first byte in bits 7:0. The key enters the buffer at the clock edge that consumes its eighth byte.
- R4: The buffer holds DEPTH keys (default 2). `prng_en` equals "seeded and buffer not full". The generator state does not advance while `prng_en` is 0.
- R5: While the block waits for a key and the buffer is non-empty, `key_out` shows the oldest buffered key in the same cycle, and that key is installed at the next edge. `stall` is 1 exactly when the block is waiting and the buffer is empty.
- R6: An installed key stays on `key_out` for exactly P accepted messages, where P is the renewal period. After the P-th accept, the next key comes from the buffer in first-in first-out order.
- R7: A `msg_accept` pulse in a cycle where `stall` is 1 is ignored and does not count toward any window.
- R8: A limit write below 2 stores 2. A period write of 0 stores 1. Whenever a write would leave the period greater than or equal to the limit, the period becomes limit-1. This also applies when the limit is lowered below the current period. A period change applies to the window in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load seed and restart key sequence |
| seed_data | input | 128 | Generator seed |
| cfg_limit_we | input | 1 | Write security limit |
| cfg_limit | input | 16 | Security limit value |
| cfg_period_we | input | 1 | Write renewal period |
| cfg_period | input | 16 | Renewal period value (messages per key) |
| msg_accept | input | 1 | One message transferred this cycle |
| key_out | output | 64 | Current scrambling network key |
| stall | output | 1 | No key available; hold traffic |
| prng_en | output | 1 | Generator clock enable |

## Verification
The bench compares `key_out`, `stall` and `prng_en` against a behavioural model on every cycle. It uses four message patterns. Sparse accepts, with a window longer than the eight-cycle refill time, show that gating alone is handled. Back-to-back accepts with a short period force stalls and show that stalled pulses are dropped. Random accepts test the window counting. The runs are split by seed reloads, including one that lands in the middle of a key build. A sequence of limit and period writes, some of them out of range, checks every clamp rule through the lengths of the key windows that follow.

// File: rtl/keyren_pkg.sv
package keyren_pkg;

    localparam int SEED_W = 128;
    localparam int BYTE_W = 8;

    typedef logic [SEED_W-1:0] seed_t;

    typedef struct packed {
        seed_t              state;
        logic [BYTE_W-1:0]  out;
    } lfsr_step_t;

    // One enabled cycle: BYTE_W single-bit shifts of the 128-bit register.
    function automatic lfsr_step_t lfsr_adv(seed_t s);
        lfsr_step_t r;
        logic       fb;
        r.state = s;
        r.out   = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            fb       = r.state[127] ^ r.state[125] ^ r.state[100] ^ r.state[98];
            r.out[i] = fb;
            r.state  = {r.state[SEED_W-2:0], fb};
        end
        return r;
    endfunction

endpackage

// File: rtl/keyren_gen.sv
module keyren_gen
    import keyren_pkg::*;
#(
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  seed_t            seed,
    input  logic             run,
    output logic             seeded,
    output logic             push,
    output logic [KEY_W-1:0] push_key
);
    localparam int STEPS = KEY_W / BYTE_W;
    localparam int SC_W  = (STEPS > 1) ? $clog2(STEPS) : 1;

    seed_t            st;
    logic [SC_W-1:0]  step;
    logic [KEY_W-1:0] part;
    lfsr_step_t       nx;
    logic             last;

    always_comb begin
        nx       = lfsr_adv(st);
        push_key = part;
        push_key[step*BYTE_W +: BYTE_W] = nx.out;
    end

    assign last = (step == SC_W'(STEPS-1));
    assign push = run && !load && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            step   <= '0;
            part   <= '0;
            seeded <= 1'b0;
        end else if (load) begin
            st     <= seed;
            step   <= '0;
            part   <= '0;
            seeded <= 1'b1;
        end else if (run) begin
            st   <= nx.state;
            part <= push_key;
            step <= last ? '0 : step + 1'b1;
        end
    end

    generate
        if (STEPS > 1) begin : g_cadence
            // R3: one key per STEPS enabled cycles, never two pushes in a row
            a_r3_push_spacing: assert property (@(posedge clk) disable iff (rst)
                push |=> !push);
        end
    endgenerate

endmodule

// File: rtl/keyren_fifo.sv
module keyren_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd, wr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd    <= '0;
            wr    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wr] <= din;
                wr      <= nxt(wr);
            end
            if (pop) rd <= nxt(rd);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R4: generator gating keeps the buffer from overflowing
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |-> !full);
    // R5: a key is only taken when one is present
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> !empty);

endmodule

// File: rtl/keyren_window.sv
module keyren_window #(
    parameter int KEY_W      = 64,
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 4,
    parameter int DEF_LIMIT  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             msg_accept,
    input  logic             cfg_limit_we,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             cfg_period_we,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             fifo_empty,
    input  logic [KEY_W-1:0] fifo_head,
    output logic             pop,
    output logic [KEY_W-1:0] key_out,
    output logic             stall
);
    localparam logic [CNT_W-1:0] MIN_LIMIT = CNT_W'(2);

    logic             key_ok;
    logic [KEY_W-1:0] key_reg;
    logic [CNT_W-1:0] cnt, period, limit;
    logic [CNT_W-1:0] cur_cnt, limit_n, per_raw, per_n;
    logic             install, acc, win_end;

    always_comb begin
        install = !key_ok && !fifo_empty;
        acc     = msg_accept && (key_ok || !fifo_empty);
        cur_cnt = key_ok ? cnt : '0;
        win_end = acc && (({1'b0, cur_cnt} + 1'b1) >= {1'b0, period});
        pop     = install && !load;
        stall   = !key_ok && fifo_empty;
        key_out = (key_ok || fifo_empty) ? key_reg : fifo_head;

        limit_n = cfg_limit_we ? ((cfg_limit < MIN_LIMIT) ? MIN_LIMIT : cfg_limit) : limit;
        per_raw = cfg_period_we ? cfg_period : period;
        if (per_raw == '0)          per_n = CNT_W'(1);
        else if (per_raw >= limit_n) per_n = limit_n - 1'b1;
        else                         per_n = per_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_ok  <= 1'b0;
            key_reg <= '0;
            cnt     <= '0;
            period  <= CNT_W'(DEF_PERIOD);
            limit   <= CNT_W'(DEF_LIMIT);
        end else begin
            limit  <= limit_n;
            period <= per_n;
            if (load) begin
                key_ok <= 1'b0;
                cnt    <= '0;
            end else if (win_end) begin
                key_ok <= 1'b0;
                cnt    <= '0;
                if (install) key_reg <= fifo_head;
            end else if (install) begin
                key_reg <= fifo_head;
                key_ok  <= 1'b1;
                cnt     <= acc ? CNT_W'(1) : '0;
            end else if (acc) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: period register always in [1, limit-1]
    a_r8_period_range: assert property (@(posedge clk) disable iff (rst)
        (period != '0) && (period < limit));
    // R8: limit never below its floor
    a_r8_limit_floor: assert property (@(posedge clk) disable iff (rst)
        limit >= MIN_LIMIT);
    // R6: an installed key does not change while it stays installed
    a_r6_key_held: assert property (@(posedge clk) disable iff (rst)
        key_ok |=> (key_ok -> (key_reg == $past(key_reg))));
    // R7: an accept during a stall leaves the window counter at zero
    a_r7_stalled_msg_dropped: assert property (@(posedge clk) disable iff (rst)
        (msg_accept && stall && !load) |=> (cnt == '0));

endmodule

// File: rtl/keyren_top.sv
module keyren_top
    import keyren_pkg::*;
#(
    parameter int KEY_W      = 64,
    parameter int DEPTH      = 2,
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 4,
    parameter int DEF_LIMIT  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [SEED_W-1:0] seed_data,
    input  logic              cfg_limit_we,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic              cfg_period_we,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic              msg_accept,
    output logic [KEY_W-1:0]  key_out,
    output logic              stall,
    output logic              prng_en
);
    logic             seeded, push, pop, empty, full;
    logic [KEY_W-1:0] push_key, head;

    assign prng_en = seeded && !full;

    keyren_gen #(.KEY_W(KEY_W)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_load),
        .seed     (seed_data),
        .run      (prng_en),
        .seeded   (seeded),
        .push     (push),
        .push_key (push_key)
    );

    keyren_fifo #(.W(KEY_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .flush (seed_load),
        .push  (push),
        .din   (push_key),
        .pop   (pop),
        .head  (head),
        .empty (empty),
        .full  (full)
    );

    keyren_window #(
        .KEY_W(KEY_W), .CNT_W(CNT_W),
        .DEF_PERIOD(DEF_PERIOD), .DEF_LIMIT(DEF_LIMIT)
    ) u_win (
        .clk           (clk),
        .rst           (rst),
        .load          (seed_load),
        .msg_accept    (msg_accept),
        .cfg_limit_we  (cfg_limit_we),
        .cfg_limit     (cfg_limit),
        .cfg_period_we (cfg_period_we),
        .cfg_period    (cfg_period),
        .fifo_empty    (empty),
        .fifo_head     (head),
        .pop           (pop),
        .key_out       (key_out),
        .stall         (stall)
    );

    // R4: generator is gated off before the first seed
    a_r4_idle_until_seeded: assert property (@(posedge clk) disable iff (rst)
        !seeded |-> !prng_en);

endmodule

// File: tb/sim_keyren_top.sv
module sim_keyren_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_load = 1'b0;
    logic [127:0] seed_data = '0;
    logic         cfg_limit_we = 1'b0, cfg_period_we = 1'b0, msg_accept = 1'b0;
    logic [15:0]  cfg_limit = '0, cfg_period = '0;
    logic [63:0]  key_out;
    logic         stall, prng_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyren_top u0 (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_data(seed_data),
        .cfg_limit_we(cfg_limit_we), .cfg_limit(cfg_limit),
        .cfg_period_we(cfg_period_we), .cfg_period(cfg_period),
        .msg_accept(msg_accept), .key_out(key_out), .stall(stall), .prng_en(prng_en)
    );

    int    n_checks = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference
    logic [127:0] m_st;
    int           m_step, m_cnt, m_per, m_lim;
    logic [63:0]  m_part, m_cur;
    logic [63:0]  m_q[$];
    bit           m_seeded, m_kok;

    task automatic model_reset();
        m_st = '0; m_step = 0; m_part = '0; m_cur = '0; m_q.delete();
        m_seeded = 0; m_kok = 0; m_cnt = 0; m_per = 4; m_lim = 64;
    endtask

    task automatic model_step(bit r, bit ld, logic [127:0] sd, bit lw, int lv,
                              bit pw, int pv, bit acc);
        int lim_n, per_n, c;
        bit gen_on, had, acc_ok, inst;
        logic [63:0] hd;
        logic [7:0]  b;
        logic        f;
        if (r) begin model_reset(); return; end
        lim_n = lw ? ((lv < 2) ? 2 : lv) : m_lim;
        per_n = pw ? pv : m_per;
        if (per_n == 0) per_n = 1;
        if (per_n >= lim_n) per_n = lim_n - 1;
        if (ld) begin
            m_st = sd; m_step = 0; m_part = '0; m_q.delete();
            m_seeded = 1; m_kok = 0; m_cnt = 0;
        end else begin
            gen_on = m_seeded && (m_q.size() < DEPTH);
            had    = m_q.size() > 0;
            hd     = had ? m_q[0] : '0;
            c      = m_kok ? m_cnt : 0;
            acc_ok = acc && (m_kok || had);
            inst   = !m_kok && had;
            if (acc_ok && (c + 1 >= m_per)) begin
                m_kok = 0; m_cnt = 0;
                if (inst) begin m_cur = hd; void'(m_q.pop_front()); end
            end else if (inst) begin
                m_cur = hd; void'(m_q.pop_front()); m_kok = 1; m_cnt = acc_ok ? 1 : 0;
            end else if (acc_ok) begin
                m_cnt++;
            end
            if (gen_on) begin
                for (int i = 0; i < 8; i++) begin
                    f = m_st[127] ^ m_st[125] ^ m_st[100] ^ m_st[98];
                    b[i] = f;
                    m_st = {m_st[126:0], f};
                end
                m_part[m_step*8 +: 8] = b;
                if (m_step == 7) begin m_q.push_back(m_part); m_step = 0; end
                else m_step++;
            end
        end
        m_lim = lim_n; m_per = per_n;
    endtask

    task automatic compare();
        bit          e_stall, e_en;
        logic [63:0] e_key;
        e_stall = !m_kok && (m_q.size() == 0);
        e_en    = m_seeded && (m_q.size() < DEPTH);
        e_key   = m_kok ? m_cur : ((m_q.size() > 0) ? m_q[0] : m_cur);
        n_checks++;
        if (stall !== e_stall || prng_en !== e_en || key_out !== e_key) begin
            n_fail++;
            $display("FAIL [%s] t=%0t stall=%b/%b prng_en=%b/%b key_out=%h/%h (actual/expected)",
                     tag, $time, stall, e_stall, prng_en, e_en, key_out, e_key);
        end
    endtask

    task automatic step(bit acc = 0, bit ld = 0, logic [127:0] sd = '0,
                        bit lw = 0, int lv = 0, bit pw = 0, int pv = 0, bit r = 0);
        @(negedge clk);
        compare();
        rst = r; msg_accept = acc; seed_load = ld; seed_data = sd;
        cfg_limit_we = lw; cfg_limit = 16'(lv); cfg_period_we = pw; cfg_period = 16'(pv);
        model_step(r, ld, sd, lw, lv, pw, pv, acc);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL [watchdog] run did not finish: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        @(posedge clk);
        // R1: reset state
        tag = "R1";
        step(.r(1)); step(.r(1));
        repeat (3) step();
        // R2: first seed load, R3: key construction from generator bytes
        tag = "R2"; step(.ld(1), .sd(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210));
        tag = "R3"; repeat (20) step();
        // R4: buffer full -> generator gated
        tag = "R4"; repeat (10) step();
        // R6: sparse accepts, window longer than refill
        tag = "R6";
        for (int i = 0; i < 60; i++) step(.acc(i % 3 == 0));
        // R5: back-to-back accepts with period 4 drain buffer -> stalls
        tag = "R5"; repeat (40) step(.acc(1));
        // R7: reload then accept continuously while the first key builds
        tag = "R7"; step(.ld(1), .sd(128'hdead_beef_0000_1111_2222_3333_4444_5555));
        repeat (14) step(.acc(1));
        // R8: clamp rules
        tag = "R8";
        step(.lw(1), .lv(5), .pw(1), .pv(9));           // period -> 4
        repeat (30) step(.acc(1));
        step(.pw(1), .pv(0));                            // period -> 1
        repeat (20) step(.acc(1));
        step(.lw(1), .lv(1));                            // limit -> 2, period 1
        repeat (20) step(.acc(1));
        step(.lw(1), .lv(64)); step(.pw(1), .pv(40));    // period 40
        step(.lw(1), .lv(10));                           // period -> 9
        for (int i = 0; i < 40; i++) step(.acc(i % 2 == 0));
        // R6: random accept pattern, period 3
        tag = "R6"; step(.pw(1), .pv(3));
        for (int i = 0; i < 150; i++) step(.acc($urandom_range(0, 1) == 1));
        // R2: reload in the middle of a partly built key
        tag = "R2";
        repeat (3) step(.acc(1));
        step(.ld(1), .sd(128'h8000_0000_0000_0000_0000_0000_0000_0001));
        for (int i = 0; i < 60; i++) step(.acc($urandom_range(0, 3) != 0));
        step();
        summary();
        $finish;
    end
endmodule